// File: doc/BRIEF.md
# Positional population count engine

The engine counts, for each of the eight bit positions of a byte, how many bytes in a stream had that bit set. A command gives the stream length in bytes. The bytes then arrive in groups of up to eight lanes. Each lane group forms an 8x8 bit grid. The grid is turned into eight bit-planes, so that plane k holds bit k of every lane. Each plane is counted with an ordinary population count, and the eight partial counts are added in parallel to eight saturating accumulators.

Lanes that fall beyond the requested length, or beyond the lane count supplied with the group, are forced to zero before the transpose. A short final group therefore adds nothing for its empty lanes. After each group the remaining length drops by a full group of eight, whatever the number of lanes taken. The command ends with the group that brings the remaining length to zero or below. A one-cycle done pulse then marks that the accumulator outputs hold the final counts.

Top module: `pos_popcnt_engine`

## Requirements
- R1: A start command is accepted only while the engine is idle (in_ready_o low). Accepting it clears all eight counts and loads the length. A start raised while a command is running is ignored and leaves the counts and the run unchanged.
- R2: A start with length 0 raises done_o in the next cycle. All counts read zero and in_ready_o stays low, so no group is taken.
- R3: A group is taken only in a cycle where in_valid_i and in_ready_o are both high. in_ready_o stays high for the whole run, including cycles where in_valid_i is low.
- R4: Lane i is in_data_i[8*i+7:8*i]. A group takes min(8, in_count_i, remaining length) lanes, counted from lane 0. All other lanes are treated as zero and add nothing to any count.
- R5: count_o[k*ACC_W +: ACC_W] is the count for bit position k. Each taken group raises it by the number of taken lanes with bit k set. The new value is visible in the cycle after the group is taken.
- R6: Each taken group lowers the remaining length by 8. The group taken while the remaining length is 8 or less is the final one, and in_ready_o is low from the next cycle.
- R7: done_o is high for exactly one cycle, the cycle after the final group is taken. In that cycle the counts already include the final group.
- R8: Between done_o and the next accepted start, the counts stay constant whatever the inputs do.
- R9: Each count saturates at 2^ACC_W-1 and never wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start command |
| len_i | input | LEN_W | Stream length in bytes, sampled with start |
| in_valid_i | input | 1 | Group valid |
| in_ready_o | output | 1 | Engine ready for a group |
| in_data_i | input | LANES*8 | Group bytes, lane i at bits 8*i+7:8*i |
| in_count_i | input | $clog2(LANES+1) | Lanes present in the group |
| count_o | output | 8*ACC_W | Per-position counts, position k at k*ACC_W |
| done_o | output | 1 | One-cycle end-of-command pulse |

## Verification
Two things can fall in the same cycle: a group transfer and a new start command. The bench raises start_i with a different length in the same cycle as a mid-stream group. It then checks that the run continues and that in_ready_o stays high. The final counts must include every group of the original length and nothing else. A second case raises start_i with length 0 in the cycle that done_o is high. It checks that the done from the zero-length command follows at once and that the counts read zero.

// File: rtl/pos_popcnt_pkg.sv
package pos_popcnt_pkg;
  localparam int unsigned BYTE_W = 8;

  function automatic int unsigned min3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a < b) ? a : b;
    return (m < c) ? m : c;
  endfunction
endpackage

// File: rtl/ppc_transpose.sv
module ppc_transpose #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [LANES*BYTE_W-1:0] lanes_i,
  output logic [BYTE_W*LANES-1:0] planes_o
);
  // plane k, bit i  <=  lane i, bit k
  for (genvar k = 0; k < BYTE_W; k++) begin : g_plane
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign planes_o[k*LANES + i] = lanes_i[i*BYTE_W + k];
    end
  end
endmodule

// File: rtl/ppc_plane_count.sv
module ppc_plane_count #(
  parameter int unsigned LANES = 8,
  localparam int unsigned PC_W = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0] plane_i,
  output logic [PC_W-1:0]  cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < LANES; i++) cnt_o = cnt_o + PC_W'(plane_i[i]);
  end
endmodule

// File: rtl/ppc_sat_acc.sv
module ppc_sat_acc #(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned INC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             add_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum   = {1'b0, acc_q} + (ACC_W+1)'(inc_i);
  assign acc_o = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (add_i) acc_q <= sum[ACC_W] ? {ACC_W{1'b1}} : sum[ACC_W-1:0];
  end

  assert_no_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> acc_q >= $past(acc_q));
  assert_sat_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && acc_q == {ACC_W{1'b1}}) |=> acc_q == {ACC_W{1'b1}});
  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !add_i) |=> $stable(acc_q));
endmodule

// File: rtl/pos_popcnt_engine.sv
module pos_popcnt_engine
  import pos_popcnt_pkg::*;
#(
  parameter int unsigned LANES = 8,
  parameter int unsigned ACC_W = 32,
  parameter int unsigned LEN_W = 16,
  localparam int unsigned CNT_W = $clog2(LANES + 1),
  localparam int unsigned PC_W  = $clog2(LANES + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [LEN_W-1:0]          len_i,
  input  logic                      in_valid_i,
  output logic                      in_ready_o,
  input  logic [LANES*BYTE_W-1:0]   in_data_i,
  input  logic [CNT_W-1:0]          in_count_i,
  output logic [BYTE_W*ACC_W-1:0]   count_o,
  output logic                      done_o
);
  logic             busy_q, done_q;
  logic [LEN_W-1:0] rem_q;
  logic             start_ok, xfer, last_grp;
  logic [LANES*BYTE_W-1:0] masked;
  logic [BYTE_W*LANES-1:0] planes;

  assign start_ok   = start_i && !busy_q;
  assign xfer       = in_valid_i && busy_q;
  assign last_grp   = rem_q <= LEN_W'(LANES);
  assign in_ready_o = busy_q;
  assign done_o     = done_q;

  // zero every lane past the lane count or the remaining length
  for (genvar i = 0; i < LANES; i++) begin : g_mask
    logic keep;
    assign keep = (CNT_W'(i) < in_count_i) && (LEN_W'(i) < rem_q);
    assign masked[i*BYTE_W +: BYTE_W] = keep ? in_data_i[i*BYTE_W +: BYTE_W] : '0;
  end

  ppc_transpose #(.LANES(LANES), .BYTE_W(BYTE_W)) u_xpose (
    .lanes_i (masked),
    .planes_o(planes)
  );

  for (genvar k = 0; k < BYTE_W; k++) begin : g_pos
    logic [PC_W-1:0] pc;
    ppc_plane_count #(.LANES(LANES)) u_cnt (
      .plane_i(planes[k*LANES +: LANES]),
      .cnt_o  (pc)
    );
    ppc_sat_acc #(.ACC_W(ACC_W), .INC_W(PC_W)) u_acc (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (start_ok),
      .add_i (xfer),
      .inc_i (pc),
      .acc_o (count_o[k*ACC_W +: ACC_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rem_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_ok) begin
        rem_q  <= len_i;
        busy_q <= (len_i != '0);
        done_q <= (len_i == '0);
      end else if (xfer) begin
        // full group step, even for a short final group
        rem_q <= last_grp ? '0 : rem_q - LEN_W'(LANES);
        if (last_grp) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assert_zero_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_ok && len_i == '0) |=> (done_o && !in_ready_o));
  assert_ready_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer && last_grp) |=> !in_ready_o);
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !done_o);
  assert_start_ignored_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && start_i && !(in_valid_i && last_grp)) |=> in_ready_o);
  assert_hold_ready_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && !in_valid_i) |=> in_ready_o);
endmodule

// File: tb/tb_pos_popcnt_engine.sv
module tb_pos_popcnt_engine;
  localparam int LANES = 8;
  localparam int ACC_W = 6;
  localparam int LEN_W = 16;
  localparam int MAXC  = (1 << ACC_W) - 1;

  logic clk_i = 0, rst_ni = 0;
  logic start_i = 0, in_valid_i = 0;
  logic [LEN_W-1:0] len_i = '0;
  logic [63:0] in_data_i = '0;
  logic [3:0] in_count_i = '0;
  logic in_ready_o, done_o;
  logic [8*ACC_W-1:0] count_o;

  int checks = 0, errors = 0;
  int exp_c [8];
  int rem;

  always #5 clk_i = ~clk_i;

  pos_popcnt_engine #(.LANES(LANES), .ACC_W(ACC_W), .LEN_W(LEN_W)) dut (
    .clk_i, .rst_ni, .start_i, .len_i, .in_valid_i, .in_ready_o,
    .in_data_i, .in_count_i, .count_o, .done_o
  );

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_counts(string req);
    for (int k = 0; k < 8; k++)
      chk(req, $sformatf("count[%0d]", k), count_o[k*ACC_W +: ACC_W], exp_c[k]);
  endtask

  task automatic start_cmd(int len);
    @(negedge clk_i);
    start_i = 1; len_i = LEN_W'(len);
    @(negedge clk_i);
    start_i = 0;
    rem = len;
    for (int k = 0; k < 8; k++) exp_c[k] = 0;
  endtask

  // one group; optional concurrent start with a different length
  task automatic push(logic [63:0] d, int cnt, bit also_start, string req);
    int take;
    bit last;
    @(negedge clk_i);
    in_valid_i = 1; in_data_i = d; in_count_i = 4'(cnt);
    if (also_start) begin start_i = 1; len_i = 16'd3; end
    take = cnt; if (rem < take) take = rem; if (take > 8) take = 8;
    for (int i = 0; i < take; i++)
      for (int k = 0; k < 8; k++)
        if (d[i*8+k] && exp_c[k] < MAXC) exp_c[k]++;
    last = (rem <= 8);
    rem -= 8;
    @(negedge clk_i);
    in_valid_i = 0; start_i = 0;
    chk_counts(req);
    chk("R7", "done after group", done_o, last);
    chk("R6", "ready after group", in_ready_o, !last);
  endtask

  task automatic t_reset;
    chk("R1", "reset ready", in_ready_o, 0);
    chk("R7", "reset done", done_o, 0);
    for (int k = 0; k < 8; k++) exp_c[k] = 0;
    chk_counts("R1");
  endtask

  task automatic t_full_groups;
    start_cmd(16);
    chk("R3", "ready in run", in_ready_o, 1);
    push(64'h0102_0408_1020_4080, 8, 0, "R5");
    push(64'hFF00_FF00_0F0F_F0F0, 8, 0, "R5");
    @(negedge clk_i);
    chk("R7", "done one cycle", done_o, 0);
  endtask

  task automatic t_positions;
    start_cmd(8);
    push(64'h8080_8040_2010_0101, 8, 0, "R5");
  endtask

  task automatic t_short_tail;
    start_cmd(11);
    push(64'h0000_0000_0000_0000, 8, 0, "R4");
    push(64'hFFFF_FFFF_FFFF_FFFF, 8, 0, "R4");
    chk("R4", "tail bit0 count", exp_c[0], 3);
  endtask

  task automatic t_lane_count;
    start_cmd(8);
    push(64'hFFFF_FF00_0000_0001, 5, 0, "R4");
  endtask

  task automatic t_valid_gating;
    logic [8*ACC_W-1:0] snap;
    @(negedge clk_i);
    in_valid_i = 1; in_data_i = '1; in_count_i = 8;
    snap = count_o;
    repeat (2) @(negedge clk_i);
    in_valid_i = 0;
    chk("R3", "idle valid ignored", count_o, snap);
    start_cmd(9);
    repeat (3) @(negedge clk_i);
    chk("R3", "ready held, no valid", in_ready_o, 1);
    chk_counts("R3");
    push(64'h0303_0303_0303_0303, 8, 0, "R3");
    push(64'h0000_0000_0000_0080, 8, 0, "R6");
  endtask

  task automatic t_start_while_busy;
    start_cmd(24);
    push(64'h1111_1111_1111_1111, 8, 0, "R1");
    push(64'h2222_2222_2222_2222, 8, 1, "R1");
    push(64'h4444_4444_4444_4444, 8, 0, "R1");
  endtask

  task automatic t_hold_after_done;
    logic [8*ACC_W-1:0] snap;
    snap = count_o;
    @(negedge clk_i);
    in_valid_i = 1; in_data_i = '1; in_count_i = 8;
    repeat (3) @(negedge clk_i);
    in_valid_i = 0;
    chk("R8", "counts held", count_o, snap);
  endtask

  task automatic t_zero_len;
    start_cmd(16);
    push(64'hFFFF_FFFF_FFFF_FFFF, 8, 0, "R2");
    // zero-length start in the done cycle
    push(64'h0, 8, 0, "R2");
    start_i = 1; len_i = '0;
    @(negedge clk_i);
    start_i = 0;
    for (int k = 0; k < 8; k++) exp_c[k] = 0;
    chk("R2", "done after zero len", done_o, 1);
    chk("R2", "ready after zero len", in_ready_o, 0);
    chk_counts("R2");
    @(negedge clk_i);
    chk("R2", "done pulse ends", done_o, 0);
    chk("R2", "ready stays low", in_ready_o, 0);
  endtask

  task automatic t_saturate;
    start_cmd(80);
    for (int g = 0; g < 10; g++) push(64'hFFFF_FFFF_FFFF_FFFF, 8, 0, "R9");
    chk("R9", "saturated bit7", count_o[7*ACC_W +: ACC_W], MAXC);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_full_groups();
    t_positions();
    t_short_tail();
    t_lane_count();
    t_valid_gating();
    t_start_while_busy();
    t_hold_after_done();
    t_zero_len();
    t_saturate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule